// File: doc/BRIEF.md
# Half-to-Single Precision Widening Converter

This block turns a 16-bit IEEE 754 half-precision bit pattern into the 32-bit single-precision pattern of the same value. The conversion is always exact, so the block does no rounding. Normal numbers have their exponent rebiased. Subnormal halves are renormalised to single-precision normals, with the shift taken from a leading-zero count. Signed zeros and infinities map to their single-precision counterparts. A NaN keeps its sign and its payload, which moves to the top of the wider fraction.

The datapath has no case split. The half word is aligned to the top of a 32-bit word. A shift amount comes from a leading-zero count. An add-then-arithmetic-shift probe forces the all-ones exponent for infinities and NaNs, and a mask built from a decrement clears the result when the magnitude is zero. The sign is ORed back in at the end.

A valid/data pair goes in and a valid/data pair comes out. The parameter `OUT_REG` adds one output register, which loads only on a valid input and otherwise keeps its value. When `OUT_REG` is 0 the unit is purely combinational.

Top module: `half_to_single_cvt`

## Requirements
- R1: A normal half (exponent field bits 14:10 in 1..30) produces the same sign, an exponent of the half exponent plus 112 in bits 30:23, and the 10-bit half fraction in bits 22:13 with bits 12:0 zero. For example, 0x4BE0 gives 0x417C0000 and 0xC540 gives 0xC0A80000.
- R2: A zero magnitude (half bits 14:0 all zero) gives zeros in bits 30:0 and keeps the sign: 0x0000 gives 0x00000000 and 0x8000 gives 0x80000000.
- R3: A subnormal half (exponent field 0, fraction non-zero) gives a normal single, with the leading fraction one made implicit and the exponent set to 103 plus that one's bit index. For example, 0x0001 gives 0x33800000 and 0x03FF gives 0x387FC000.
- R4: An infinity gives a single-precision infinity with the same sign: 0x7C00 gives 0x7F800000 and 0xFC00 gives 0xFF800000.
- R5: A NaN (exponent field 31, fraction non-zero) gives exponent 0xFF, the half fraction in bits 22:13, zeros in bits 12:0 and the same sign, so the output fraction is never zero.
- R6: Output bit 31 always equals input bit 15.
- R7: With OUT_REG=1, out_valid equals the in_valid of the previous clock cycle. While rst_n is low, out_valid and out_single are 0. Every valid input produces exactly one valid output, in order.
- R8: With OUT_REG=1, out_single keeps its value through any cycle in which in_valid is low, whatever is on in_half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | in_half carries a value to convert |
| in_half | input | 16 | Half-precision bit pattern |
| out_valid | output | 1 | out_single carries a converted value |
| out_single | output | 32 | Single-precision bit pattern |

## Verification
The named values come first: the two signed decimal examples, both zeros, both infinities, quiet and signalling NaNs with several payloads, the smallest and largest subnormals, and the extremes of the normal range. Together these separate the rebias path, the renormalising shift, the special-value probe and the zero mask. Then every one of the 65536 input codes is streamed back to back and compared with a case-split reference model. This catches errors in the leading-zero count at every group boundary and off-by-one errors in the shift threshold. Idle gaps with junk on the data input show that the register holds its value and that valid is exactly one cycle late.

// File: rtl/h2s_pkg.sv
package h2s_pkg;

  localparam int HALF_W      = 16;
  localparam int HALF_EXP_W  = 5;
  localparam int HALF_FRAC_W = HALF_W - 1 - HALF_EXP_W;
  localparam int SGL_W       = 32;
  localparam int SGL_EXP_W   = 8;
  localparam int SGL_FRAC_W  = SGL_W - 1 - SGL_EXP_W;

  // derived layout constants
  localparam int ALIGN_W  = SGL_W - HALF_W;
  localparam int EXP_GAP  = SGL_EXP_W - HALF_EXP_W;
  localparam int BIAS_GAP = (2 ** (SGL_EXP_W - 1) - 1) - (2 ** (HALF_EXP_W - 1) - 1);
  localparam int LZ_W     = $clog2(SGL_W + 1);
  localparam int ETERM_W  = SGL_W - SGL_FRAC_W;

  typedef logic [HALF_W-1:0] half_t;
  typedef logic [SGL_W-1:0]  sgl_t;
  typedef logic [LZ_W-1:0]   lz_t;

  localparam sgl_t SIGN_BIT      = sgl_t'(1) << (SGL_W - 1);
  localparam sgl_t EXP_FIELD     = ((sgl_t'(1) << SGL_EXP_W) - sgl_t'(1)) << SGL_FRAC_W;
  localparam sgl_t SPECIAL_PROBE = sgl_t'(1) << (SGL_W - 1 - HALF_EXP_W);

  // A normal half leaves at most HALF_EXP_W leading zeros; anything beyond is renormalised.
  function automatic lz_t renorm_shift_of(lz_t lz);
    return (lz > lz_t'(HALF_EXP_W)) ? lz - lz_t'(HALF_EXP_W) : '0;
  endfunction

  // An all-ones exponent carries into the top bit; the arithmetic shift smears it over the exponent.
  function automatic sgl_t special_mask_of(sgl_t ns);
    logic signed [SGL_W-1:0] probe;
    probe = signed'(ns + SPECIAL_PROBE);
    return sgl_t'(probe >>> SGL_EXP_W) & EXP_FIELD;
  endfunction

  // All ones only when the magnitude is zero (the decrement wraps negative).
  function automatic sgl_t zero_mask_of(sgl_t ns);
    logic signed [SGL_W-1:0] dec;
    dec = signed'(ns - sgl_t'(1));
    return sgl_t'(dec >>> (SGL_W - 1));
  endfunction

  // Only the bits that land at and above the fraction field are kept.
  function automatic logic [ETERM_W-1:0] exp_term_of(lz_t sh);
    return ETERM_W'(BIAS_GAP) - ETERM_W'(sh);
  endfunction

  function automatic sgl_t magnitude_of(sgl_t ns, lz_t sh);
    sgl_t body;
    body = (ns << sh) >> EXP_GAP;
    return body + {exp_term_of(sh), {SGL_FRAC_W{1'b0}}};
  endfunction

endpackage

// File: rtl/h2s_lead_zero.sv
module h2s_lead_zero #(
  parameter  int W   = 32,
  parameter  int GRP = 4,
  localparam int CW  = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count
);

  localparam int NG  = W / GRP;
  localparam int GLW = (GRP > 1) ? $clog2(GRP) : 1;

  logic [NG-1:0]           grp_empty;
  logic [NG-1:0][GLW-1:0]  grp_lead;

  // group 0 holds the most significant bits
  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic [GRP-1:0] slice;
    logic [GLW-1:0] lead;

    assign slice = vec[W-1-g*GRP -: GRP];

    always_comb begin
      lead = '0;
      for (int b = 0; b < GRP; b++) begin
        if (slice[b]) lead = GLW'(GRP - 1 - b);
      end
    end

    assign grp_empty[g] = ~|slice;
    assign grp_lead[g]  = lead;
  end

  always_comb begin
    count = CW'(W);
    for (int g = NG - 1; g >= 0; g--) begin
      if (!grp_empty[g]) count = CW'(g * GRP) + CW'(grp_lead[g]);
    end
  end

endmodule

// File: rtl/h2s_mask_core.sv
module h2s_mask_core
  import h2s_pkg::*;
(
  input  half_t half_in,
  output sgl_t  single_out,
  output lz_t   renorm_shift,
  output logic  special_hit,
  output logic  zero_hit
);

  sgl_t aligned;
  sgl_t sign_part;
  sgl_t nonsign;
  lz_t  lead_zeros;
  sgl_t special_mask;
  sgl_t zero_mask;
  sgl_t magnitude;

  assign aligned   = {half_in, {ALIGN_W{1'b0}}};
  assign sign_part = aligned & SIGN_BIT;
  assign nonsign   = aligned & ~SIGN_BIT;

  h2s_lead_zero #(
    .W   (SGL_W),
    .GRP (4)
  ) lzc_i (
    .vec   (nonsign),
    .count (lead_zeros)
  );

  assign renorm_shift = renorm_shift_of(lead_zeros);
  assign special_mask = special_mask_of(nonsign);
  assign zero_mask    = zero_mask_of(nonsign);
  assign magnitude    = magnitude_of(nonsign, renorm_shift);

  assign single_out  = sign_part | ((magnitude | special_mask) & ~zero_mask);
  assign special_hit = |special_mask;
  assign zero_hit    = zero_mask[0];

endmodule

// File: rtl/h2s_out_stage.sv
module h2s_out_stage #(
  parameter bit OUT_REG = 1'b1,
  parameter int W       = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         d_valid,
  input  logic [W-1:0] d_data,
  output logic         q_valid,
  output logic [W-1:0] q_data
);

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_valid <= 1'b0;
        q_data  <= '0;
      end else begin
        q_valid <= d_valid;
        if (d_valid) q_data <= d_data;
      end
    end
  end else begin : g_comb
    assign q_valid = d_valid;
    assign q_data  = d_data;
  end

endmodule

// File: rtl/half_to_single_cvt.sv
module half_to_single_cvt
  import h2s_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [HALF_W-1:0] in_half,
  output logic              out_valid,
  output logic [SGL_W-1:0]  out_single
);

  sgl_t conv_word;
  lz_t  renorm_shift;
  logic special_hit;
  logic zero_hit;

  h2s_mask_core core_i (
    .half_in      (in_half),
    .single_out   (conv_word),
    .renorm_shift (renorm_shift),
    .special_hit  (special_hit),
    .zero_hit     (zero_hit)
  );

  h2s_out_stage #(
    .OUT_REG (OUT_REG),
    .W       (SGL_W)
  ) out_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_valid (in_valid),
    .d_data  (conv_word),
    .q_valid (out_valid),
    .q_data  (out_single)
  );

endmodule

// File: rtl/h2s_cvt_chk.sv
module h2s_cvt_chk
  import h2s_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [HALF_W-1:0] in_half,
  input logic              out_valid,
  input logic [SGL_W-1:0]  out_single,
  input lz_t               renorm_shift,
  input logic              special_hit,
  input logic              zero_hit
);

  logic [HALF_EXP_W-1:0]  h_exp;
  logic [HALF_FRAC_W-1:0] h_frac;
  assign h_exp  = in_half[HALF_W-2 -: HALF_EXP_W];
  assign h_frac = in_half[HALF_FRAC_W-1:0];

  // R1
  normal_noshift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_exp != '0) |-> (renorm_shift == '0));

  // R3
  subnorm_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_exp == '0 && h_frac != '0) |-> (renorm_shift != '0));

  // R4
  special_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_exp == '1) |-> special_hit);

  // R1
  special_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_exp != '1) |-> !special_hit);

  // R2
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_hit |-> (h_exp == '0 && h_frac == '0));

  if (OUT_REG) begin : g_reg_chk
    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

    // R7
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

    // R8
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_single));

    // R6
    sign_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_single[SGL_W-1] == $past(in_half[HALF_W-1])));

    // R2
    zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && h_exp == '0 && h_frac == '0) |=> (out_single[SGL_W-2:0] == '0));

    // R4
    inf_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && h_exp == '1 && h_frac == '0) |=> (out_single[SGL_W-2:0] == 31'h7F80_0000));

    // R5
    nan_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && h_exp == '1 && h_frac != '0) |=>
        (out_single[SGL_W-2 -: SGL_EXP_W] == '1 && out_single[SGL_FRAC_W-1:0] != '0));
  end else begin : g_comb_chk
    // R6
    sign_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (out_single[SGL_W-1] == in_half[HALF_W-1]));

    // R7
    valid_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == in_valid);
  end

endmodule

bind half_to_single_cvt h2s_cvt_chk #(
  .OUT_REG (OUT_REG)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_half      (in_half),
  .out_valid    (out_valid),
  .out_single   (out_single),
  .renorm_shift (renorm_shift),
  .special_hit  (special_hit),
  .zero_hit     (zero_hit)
);

// File: tb/half_to_single_cvt_tb_top.sv
`timescale 1ns/1ps
module half_to_single_cvt_tb_top;

  localparam real CLK_NS = 8.0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_half;
  logic        out_valid;
  logic [31:0] out_single;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] exp_q[$];
  logic [15:0] inp_q[$];
  string       tag_q[$];
  logic [31:0] mon_last = '0;

  always #(CLK_NS / 2.0) clk = ~clk;

  half_to_single_cvt #(.OUT_REG(1'b1)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_half    (in_half),
    .out_valid  (out_valid),
    .out_single (out_single)
  );

  // Case-split reference, written independently of the mask datapath.
  function automatic logic [31:0] ref_widen(input logic [15:0] h);
    logic        s;
    logic [4:0]  e;
    logic [9:0]  f;
    logic [23:0] m;
    int          p;
    s = h[15];
    e = h[14:10];
    f = h[9:0];
    if (e == 5'h1F) return {s, 8'hFF, f, 13'd0};
    if (e == 5'h00) begin
      if (f == 10'd0) return {s, 31'd0};
      p = 0;
      for (int b = 0; b < 10; b++) if (f[b]) p = b;
      m = 24'(f) << (23 - p);
      return {s, 8'(p + 103), m[22:0]};
    end
    return {s, 8'(e) + 8'd112, f, 13'd0};
  endfunction

  function automatic string tag_of(input logic [15:0] h);
    if (h[14:10] == 5'h1F) return (h[9:0] == 10'd0) ? "R4" : "R5";
    if (h[14:10] == 5'h00) return (h[9:0] == 10'd0) ? "R2" : "R3";
    return "R1";
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, expv);
    end
  endtask

  task automatic send(input logic [15:0] h, input string tag);
    @(posedge clk);
    #1;
    in_valid = 1'b1;
    in_half  = h;
    exp_q.push_back(ref_widen(h));
    inp_q.push_back(h);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input logic [15:0] junk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_half  = junk;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 output without input", {31'd0, out_valid}, 32'd0);
      end else begin
        logic [31:0] e;
        logic [15:0] h;
        string       t;
        e = exp_q.pop_front();
        h = inp_q.pop_front();
        t = tag_q.pop_front();
        check(out_single === e, t, out_single, e);
        // R6 sign carried
        check(out_single[31] === h[15], "R6", {31'd0, out_single[31]}, {31'd0, h[15]});
        mon_last = out_single;
      end
    end
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 190000.0);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired: R7 actual=running expected=finished");
    finish_run();
  end

  initial begin
    in_valid = 1'b0;
    in_half  = 16'h0000;
    rst_n    = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7 reset state
    check(out_valid === 1'b0, "R7 reset valid", {31'd0, out_valid}, 32'd0);
    check(out_single === 32'd0, "R7 reset data", out_single, 32'd0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;

    // R1 named decimal examples
    send(16'h4BE0, "R1 15.75");
    check(ref_widen(16'h4BE0) == 32'h417C0000, "R1 model 15.75", ref_widen(16'h4BE0), 32'h417C0000);
    send(16'hC540, "R1 -5.25");
    check(ref_widen(16'hC540) == 32'hC0A80000, "R1 model -5.25", ref_widen(16'hC540), 32'hC0A80000);
    send(16'h3C00, "R1 one");
    send(16'h0400, "R1 min normal");
    send(16'h7BFF, "R1 max normal");
    // R2 signed zeros
    send(16'h0000, "R2 +0");
    send(16'h8000, "R2 -0");
    // R3 subnormals
    send(16'h0001, "R3 min subnormal");
    check(ref_widen(16'h0001) == 32'h33800000, "R3 model min sub", ref_widen(16'h0001), 32'h33800000);
    send(16'h03FF, "R3 max subnormal");
    check(ref_widen(16'h03FF) == 32'h387FC000, "R3 model max sub", ref_widen(16'h03FF), 32'h387FC000);
    send(16'h8200, "R3 neg subnormal");
    // R4 infinities
    send(16'h7C00, "R4 +inf");
    send(16'hFC00, "R4 -inf");
    // R5 NaNs
    send(16'h7E00, "R5 quiet nan");
    send(16'h7C01, "R5 signalling nan");
    send(16'hFE55, "R5 neg nan");
    idle(16'h1234);

    // R8 hold across idle cycles with junk data
    send(16'h4BE0, "R1 before hold");
    idle(16'h7E12);
    idle(16'h0001);
    @(negedge clk);
    check(out_valid === 1'b0, "R7 valid drops", {31'd0, out_valid}, 32'd0);
    check(out_single === 32'h417C0000, "R8 hold", out_single, 32'h417C0000);
    idle(16'hFFFF);
    @(negedge clk);
    check(out_single === 32'h417C0000, "R8 hold second idle", out_single, 32'h417C0000);

    // every code, back to back
    for (int v = 0; v < 65536; v++) begin
      send(16'(v), tag_of(16'(v)));
    end
    idle(16'h0000);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7 every input produced one output
    check(exp_q.size() == 0, "R7 drained", exp_q.size(), 32'd0);
    finish_run();
  end

endmodule